// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block decides whether an interrupt controller should signal its host and which request line wins. It takes the pending-request, mask and in-service vectors together with a rotation base. The line at the base position has the highest priority, and priority falls in order through the positions after it, wrapping around. The block finds the best unmasked pending line and compares its priority with the best line still in service. It raises the request only when the pending line outranks everything in service.

Two options change which in-service lines take part in that comparison. With the special-mask option, in-service lines that are currently masked are ignored, so lower-priority lines can nest under them. With the fully-nested option on a master unit, the cascade line is ignored, so a second request arriving through a slave controller can still reach the host. The block also reports the highest-priority in-service line, so that a non-specific end-of-interrupt command knows which bit to clear. The resolver has no registers of its own apart from a one-cycle registered copy of the decision.

Top module: `irq_resolver`

## Requirements
- R1: The candidate vector is `pend_i & ~mask_i`. When it is zero, `int_o` is 0.
- R2: Priority rank p (0 = highest) belongs to line (p + `base_i`) mod LINES. `win_o` is the lowest-ranked set line of the candidate vector.
- R3: `int_o` is 1 only when the candidate's rank is strictly lower than the rank of the best line in the current in-service vector. An equal rank does not raise the request.
- R4: The current in-service vector is `insvc_i`. When `spec_mask_i` is 1, lines whose `mask_i` bit is 1 are removed from it.
- R5: When `nest_i` and `master_i` are both 1, bit CASCADE_LINE (default 2) is removed from the current in-service vector. If either flag is 0, that bit counts normally.
- R6: When `int_o` is 0, `win_o` is 0. When `int_o` is 1, `win_o` names a line that is pending and unmasked.
- R7: `isv_valid_o` is 1 exactly when `insvc_i` is non-zero. `isv_o` is the lowest-ranked set line of the raw `insvc_i`, using the same rotation. It is 0 when `isv_valid_o` is 0.
- R8: `int_q_o` and `win_q_o` equal the values that `int_o` and `win_o` had at the previous rising clock edge.
- R9: While `rst_n` is 0 at a rising edge, `int_q_o` and `win_q_o` become 0. The combinational outputs do not depend on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered copy |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | LINES | Pending requests |
| mask_i | input | LINES | Mask bits, 1 = line masked |
| insvc_i | input | LINES | In-service lines |
| base_i | input | IDW | Line that currently has the top priority |
| spec_mask_i | input | 1 | Masked in-service lines are ignored |
| nest_i | input | 1 | Fully-nested option |
| master_i | input | 1 | Unit is the master of a cascade |
| int_o | output | 1 | Interrupt request, combinational |
| win_o | output | IDW | Winning line |
| isv_valid_o | output | 1 | Some line is in service |
| isv_o | output | IDW | Highest-priority in-service line |
| int_q_o | output | 1 | Registered `int_o` |
| win_q_o | output | IDW | Registered `win_o` |

## Verification
The bench builds the block with its defaults: eight lines with the cascade on line 2. At this size every rotation base can be swept, and wrap-around winners can be aimed at directly, such as base 6 choosing line 0 over line 5. The same size lets the cascade bit be exercised under all four combinations of the fully-nested and master flags. Directed cases cover the equal-rank boundary and both settings of the special mask. A long pseudo-random run then compares every output against an independent model of the rotating scan.

// File: rtl/irq_res_pkg.sv
// Shared helpers for the interrupt resolver.
// Assumes line counts up to 64.
package irq_res_pkg;

    localparam int DEF_LINES   = 8;
    localparam int DEF_CASCADE = 2;

    // Index of the lowest set bit among the first n bits, or n if none is set.
    function automatic int lowest_set(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            if (v[i]) return i;
        end
        return n;
    endfunction

endpackage

// File: rtl/irq_prio_scan.sv
// Rotating priority scan. Rank p stands for line (p + base) mod N.
// Returns the best rank (N when the vector is empty) and the matching line.
// Assumes N is a power of two, so line arithmetic wraps naturally.
module irq_prio_scan #(
    parameter int N   = 8,
    localparam int W  = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] base,
    output logic [W:0]   prio,
    output logic [W-1:0] line,
    output logic         found
);
    logic [2*N-1:0] dbl;
    logic [N-1:0]   rot;

    // Rotate so that bit p of rot holds line (p + base) mod N.
    assign dbl = {vec, vec} >> base;
    assign rot = dbl[N-1:0];

    // Find the lowest rank that holds a set bit.
    always_comb begin
        prio  = (W+1)'(irq_res_pkg::lowest_set(64'(rot), N));
        found = (prio != (W+1)'(N));
        line  = prio[W-1:0] + base;
    end
endmodule

// File: rtl/irq_cur_vector.sv
// Builds the in-service vector that sets the current priority level.
// Masked lines are dropped under the special mask. The cascade line is
// dropped on a master running the fully-nested option.
module irq_cur_vector #(
    parameter int N       = 8,
    parameter int CASCADE = 2
) (
    input  logic [N-1:0] insvc,
    input  logic [N-1:0] mask,
    input  logic         spec_mask,
    input  logic         nested,
    input  logic         is_master,
    output logic [N-1:0] cur
);
    for (genvar i = 0; i < N; i++) begin : g_line
        logic drop_mask;
        logic drop_casc;
        // Decide per line whether its in-service bit is excluded.
        assign drop_mask = spec_mask & mask[i];
        if (i == CASCADE) begin : g_casc
            assign drop_casc = nested & is_master;
        end else begin : g_plain
            assign drop_casc = 1'b0;
        end
        assign cur[i] = insvc[i] & ~drop_mask & ~drop_casc;
    end
endmodule

// File: rtl/irq_resolver.sv
// Interrupt resolver top. It compares the best unmasked pending line with
// the current in-service level and reports the winner. It also reports the
// best raw in-service line for end-of-interrupt handling.
// Assumes LINES is a power of two and the inputs come from registers.
module irq_resolver #(
    parameter int LINES        = irq_res_pkg::DEF_LINES,
    parameter int CASCADE_LINE = irq_res_pkg::DEF_CASCADE,
    localparam int IDW         = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pend_i,
    input  logic [LINES-1:0] mask_i,
    input  logic [LINES-1:0] insvc_i,
    input  logic [IDW-1:0]   base_i,
    input  logic             spec_mask_i,
    input  logic             nest_i,
    input  logic             master_i,
    output logic             int_o,
    output logic [IDW-1:0]   win_o,
    output logic             isv_valid_o,
    output logic [IDW-1:0]   isv_o,
    output logic             int_q_o,
    output logic [IDW-1:0]   win_q_o
);
    logic [LINES-1:0] cand_vec;
    logic [LINES-1:0] cur_vec;
    logic [IDW:0]     cand_prio, cur_prio, isv_prio;
    logic [IDW-1:0]   cand_line, cur_line, isv_line;
    logic             cand_found, cur_found, isv_found;
    logic             raise;

    // Unmasked pending requests.
    assign cand_vec = pend_i & ~mask_i;

    irq_prio_scan #(.N(LINES)) u_cand_scan (
        .vec(cand_vec), .base(base_i),
        .prio(cand_prio), .line(cand_line), .found(cand_found)
    );

    irq_cur_vector #(.N(LINES), .CASCADE(CASCADE_LINE)) u_cur_vec (
        .insvc(insvc_i), .mask(mask_i), .spec_mask(spec_mask_i),
        .nested(nest_i), .is_master(master_i), .cur(cur_vec)
    );

    irq_prio_scan #(.N(LINES)) u_cur_scan (
        .vec(cur_vec), .base(base_i),
        .prio(cur_prio), .line(cur_line), .found(cur_found)
    );

    irq_prio_scan #(.N(LINES)) u_isv_scan (
        .vec(insvc_i), .base(base_i),
        .prio(isv_prio), .line(isv_line), .found(isv_found)
    );

    // Raise only when the candidate strictly outranks the in-service level.
    always_comb begin
        raise       = cand_found && (cand_prio < cur_prio);
        int_o       = raise;
        win_o       = raise ? cand_line : '0;
        isv_valid_o = isv_found;
        isv_o       = isv_found ? isv_line : '0;
    end

    // Registered copy of the decision for consumers in another timing path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q_o <= 1'b0;
            win_q_o <= '0;
        end else begin
            int_q_o <= int_o;
            win_q_o <= win_o;
        end
    end

    // The current-level line is only needed for its rank.
    logic unused_cur;
    assign unused_cur = ^{cur_line, cur_found};
endmodule

// File: rtl/irq_resolver_chk.sv
// Property checker for the interrupt resolver, bound to every instance.
module irq_resolver_chk #(
    parameter int LINES = 8,
    localparam int IDW  = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] pend_i,
    input logic [LINES-1:0] mask_i,
    input logic [LINES-1:0] insvc_i,
    input logic             int_o,
    input logic [IDW-1:0]   win_o,
    input logic             isv_valid_o,
    input logic [IDW-1:0]   isv_o,
    input logic             int_q_o,
    input logic [IDW-1:0]   win_q_o
);
    p_empty_noint_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & ~mask_i) == '0) |-> !int_o);

    p_winner_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> (pend_i[win_o] && !mask_i[win_o]));

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !int_o |-> (win_o == '0));

    p_isv_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        isv_valid_o == (insvc_i != '0));

    p_isv_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        isv_valid_o |-> insvc_i[isv_o]);

    p_follow_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |=> int_q_o);

    p_follow_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_o |=> (!int_q_o && win_q_o == '0));
endmodule

bind irq_resolver irq_resolver_chk #(.LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .mask_i(mask_i),
    .insvc_i(insvc_i), .int_o(int_o), .win_o(win_o),
    .isv_valid_o(isv_valid_o), .isv_o(isv_o),
    .int_q_o(int_q_o), .win_q_o(win_q_o)
);

// File: tb/irq_resolver_tb.sv
`timescale 1ns/1ps
module irq_resolver_tb;
    localparam int N = 8;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pend = '0, mask = '0, insvc = '0;
    logic [W-1:0] base = '0;
    logic         smm = 1'b0, nest = 1'b0, mstr = 1'b0;
    logic         int_o, isv_valid_o, int_q_o;
    logic [W-1:0] win_o, isv_o, win_q_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic         intr;
        logic [W-1:0] win;
        logic         isvv;
        logic [W-1:0] isv;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    irq_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask),
        .insvc_i(insvc), .base_i(base), .spec_mask_i(smm), .nest_i(nest),
        .master_i(mstr), .int_o(int_o), .win_o(win_o),
        .isv_valid_o(isv_valid_o), .isv_o(isv_o),
        .int_q_o(int_q_o), .win_q_o(win_q_o)
    );

    // Reference rank scan: first p with line (p+b)%8 set, 8 if none.
    function automatic int scan(input logic [N-1:0] v, input int b);
        for (int p = 0; p < N; p++) if (v[(p + b) % N]) return p;
        return N;
    endfunction

    // Driver: apply one input pattern at a falling edge and queue its expectation.
    task automatic drive(input logic [N-1:0] p, input logic [N-1:0] m,
                         input logic [N-1:0] s, input int b, input logic sm,
                         input logic ne, input logic ma, input string tag);
        exp_t e;
        logic [N-1:0] cur;
        int cp, up, ip;
        @(negedge clk);
        pend = p; mask = m; insvc = s; base = W'(b);
        smm = sm; nest = ne; mstr = ma;
        cp  = scan(p & ~m, b);
        cur = s;
        if (sm) cur = cur & ~m;
        if (ne && ma) cur[2] = 1'b0;
        up  = scan(cur, b);
        ip  = scan(s, b);
        e.intr = (cp < N) && (cp < up);
        e.win  = e.intr ? W'((cp + b) % N) : '0;
        e.isvv = (ip < N);
        e.isv  = e.isvv ? W'((ip + b) % N) : '0;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // Monitor: just after each rising edge, compare outputs with the queue head.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_run++;
                if (int_o !== e.intr || win_o !== e.win) begin
                    n_fail++;
                    $display("FAIL %s: int/win got %b/%0d expected %b/%0d",
                             e.tag, int_o, win_o, e.intr, e.win);
                end else if (isv_valid_o !== e.isvv || isv_o !== e.isv) begin
                    n_fail++;
                    $display("FAIL %s: isv valid/id got %b/%0d expected %b/%0d",
                             e.tag, isv_valid_o, isv_o, e.isvv, e.isv);
                end else if (int_q_o !== e.intr || win_q_o !== e.win) begin
                    n_fail++;
                    $display("FAIL %s (R8): registered got %b/%0d expected %b/%0d",
                             e.tag, int_q_o, win_q_o, e.intr, e.win);
                end
            end
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        int unsigned x = 32'h1234_5678;
        // R9: reset holds registered outputs low even with a live request.
        pend = 8'h08;
        @(posedge clk); #1;
        chk(int_q_o, 1'b0, "R9 reset int_q");
        chk(win_q_o == '0, 1'b1, "R9 reset win_q");
        chk(int_o, 1'b1, "R1 comb output independent of reset");
        @(negedge clk); rst_n = 1'b1;

        drive(8'h00, 8'h00, 8'h00, 0, 0, 0, 0, "R1 empty");
        drive(8'h10, 8'h10, 8'h00, 0, 0, 0, 0, "R1 all masked");
        drive(8'h18, 8'h10, 8'h00, 0, 0, 0, 0, "R1 mask removes line4");
        drive(8'h21, 8'h00, 8'h00, 5, 0, 0, 0, "R2 base5 picks 5");
        drive(8'h21, 8'h00, 8'h00, 6, 0, 0, 0, "R2 base6 wraps to 0");
        drive(8'h81, 8'h00, 8'h00, 7, 0, 0, 0, "R2 base7 picks 7");
        for (int b = 0; b < N; b++)
            drive(8'hFF, 8'h00, 8'h00, b, 0, 0, 0, "R2 sweep base");
        drive(8'h08, 8'h00, 8'h08, 0, 0, 0, 0, "R3 equal rank no raise");
        drive(8'h08, 8'h00, 8'h10, 0, 0, 0, 0, "R3 higher than service");
        drive(8'h08, 8'h00, 8'h04, 0, 0, 0, 0, "R3 lower than service");
        drive(8'h08, 8'h04, 8'h04, 0, 1, 0, 0, "R4 special mask on");
        drive(8'h08, 8'h04, 8'h04, 0, 0, 0, 0, "R4 special mask off");
        drive(8'h04, 8'h00, 8'h04, 0, 0, 1, 1, "R5 nested master");
        drive(8'h04, 8'h00, 8'h04, 0, 0, 1, 0, "R5 nested slave");
        drive(8'h04, 8'h00, 8'h04, 0, 0, 0, 1, "R5 master not nested");
        drive(8'h02, 8'h00, 8'h82, 7, 0, 0, 0, "R7 isv base7");
        drive(8'h00, 8'h00, 8'h82, 0, 0, 0, 0, "R7 isv base0");
        drive(8'h40, 8'h40, 8'h00, 3, 0, 0, 0, "R6 idle win zero");
        for (int i = 0; i < 300; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            drive(x[7:0], x[15:8] & x[23:16], x[31:24] & x[11:4],
                  int'(x[26:24]), x[27], x[28], x[29], "R2 random");
        end
        @(negedge clk);
        @(negedge clk);
        // R9: reset during a live request clears the registered copy.
        pend = 8'h01; mask = '0; insvc = '0; rst_n = 1'b0;
        @(posedge clk); #1;
        chk(int_q_o, 1'b0, "R9 mid-run reset");
        finish_run();
    end
endmodule